// File: doc/BRIEF.md
# Page Write Staging Buffer

This block sits between a serial-bus slave front end and a byte-wide storage array. The front end hands it a 16-bit start address, then a stream of data bytes. The buffer collects the bytes into one page of a parameterised size, 128 bytes by default. An offset counter places each byte in the page and wraps at the page end. A per-byte mask records which offsets were actually loaded.

When the front end signals the end of a write transfer with a commit pulse, the buffer scans the page. It drives one array write for each loaded offset, in ascending offset order. It then holds `busy` for a programmable write-cycle time, given as a number of clock cycles. While `busy` is high, every request from the front end is dropped. A transfer can also be cancelled with an abort pulse, for example after a write-protect rejection. A cancelled transfer leaves the array untouched and starts no write cycle.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` is low and `arr_we` is low.
- R2: On `load_addr`, bits 15..7 of `addr_in` select the page and bits 6..0 give the starting in-page offset. Every array write for that transfer carries the selected page in `arr_addr[15:7]` and the byte offset in `arr_addr[6:0]`.
- R3: Each accepted data byte moves the offset up by one. After offset 127 the offset returns to 0 of the same page and never enters the next page.
- R4: When the offset wraps onto an offset already loaded, the later byte replaces the earlier one. Within one commit each offset is written at most once, and the writes appear in ascending offset order.
- R5: Only offsets loaded since the last `load_addr`, abort or commit are written, so the number of array writes equals the number of distinct loaded offsets. A single-byte transfer produces exactly one write.
- R6: A commit that finds at least one loaded byte raises `busy` on the next clock edge. `busy` then stays high for exactly PAGE_BYTES + WRITE_CYCLES cycles. Array writes happen only while `busy` is high.
- R7: A commit that finds no loaded byte leaves `busy` low and produces no array write.
- R8: `abort` discards all loaded bytes and starts no write cycle. `abort` outranks `commit`, `wr_valid` and `load_addr` presented in the same cycle, and none of them takes effect.
- R9: While `busy` is high, `load_addr`, `wr_valid`, `commit` and `abort` are ignored. After the cycle ends, a byte sent without a new address lands at the offset that follows the last byte of the committed transfer, in the same page.
- R10: A byte presented in the same cycle as `commit` is included in that commit. A byte presented in the same cycle as `load_addr` goes to the newly loaded offset.
- R11: `load_addr` discards bytes loaded earlier that were not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_addr | input | 1 | Start of a write transfer; latches `addr_in` |
| addr_in | input | 16 | Page (15..7) and start offset (6..0) |
| wr_valid | input | 1 | Data byte strobe |
| wr_byte | input | 8 | Data byte |
| commit | input | 1 | End of a write transfer; starts programming |
| abort | input | 1 | Cancels the current transfer |
| busy | output | 1 | Write scan and write-cycle time in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 16 | Array byte address |
| arr_wdata | output | 8 | Array write data |

## Verification
The two functions that can fall in the same cycle are the loading of a byte and the closing of a transfer, either by `commit` or by `abort`. A third pairing is a byte arriving together with a new address. The bench provokes these pairings by raising the strobes in one cycle. A byte that arrives with `commit` must show up among the captured array writes. A byte or commit that arrives with `abort` must produce no write and no busy interval. A byte that arrives with `load_addr` must land at the newly loaded offset. Randomly sized transfers that wrap the page are checked the same way against a bench-side page model.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pwb_stage.sv
`timescale 1ns/1ps
// Page staging storage: data bytes, loaded-offset mask, page and offset pointer.
module pwb_stage #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              abort,
  input  logic              clr_mask,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [PAGE_W-1:0] page_o,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mask,
  output logic              mask_any_next
);
  logic [PAGE_W-1:0]     page_q, page_d;
  logic [OFF_W-1:0]      off_q, off_d, wr_off;
  logic [PAGE_BYTES-1:0] mask_q, mask_d, hit_vec;
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic                  take_load, take_byte, drop_all;

  always_comb begin
    take_load = accept & load_addr & ~abort;
    take_byte = accept & wr_valid & ~abort;
    drop_all  = clr_mask | (accept & (abort | load_addr));
    wr_off    = take_load ? addr_in[OFF_W-1:0] : off_q;
    page_d    = take_load ? addr_in[ADDR_W-1:OFF_W] : page_q;
    off_d     = off_q;
    if (take_load) off_d = addr_in[OFF_W-1:0];
    if (take_byte) off_d = wr_off + OFF_W'(1);
  end

  for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
    always_comb begin
      hit_vec[gi] = take_byte && (wr_off == OFF_W'(gi));
      mask_d[gi]  = (drop_all ? 1'b0 : mask_q[gi]) | hit_vec[gi];
    end
    always_ff @(posedge clk) begin
      if (hit_vec[gi]) data_q[gi] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else begin
      page_q <= page_d;
      off_q  <= off_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    page_o        = page_q;
    rd_data       = data_q[rd_off];
    rd_mask       = mask_q[rd_off];
    mask_any_next = |mask_d;
  end
endmodule

// File: rtl/pwb_seq.sv
`timescale 1ns/1ps
// Commit sequencer: scans every offset once, then waits out the write-cycle time.
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold_done,
  output logic             busy,
  output logic             scan_en,
  output logic [OFF_W-1:0] scan_off,
  output logic             hold_start,
  output logic             clr_mask
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  seq_state_t       state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    scan_en    = 1'b0;
    hold_start = 1'b0;
    clr_mask   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_SCAN;
          cnt_d   = '0;
        end
      end
      SEQ_SCAN: begin
        scan_en = 1'b1;
        if (cnt_q == LAST_OFF) begin
          state_d    = SEQ_HOLD;
          hold_start = 1'b1;
          clr_mask   = 1'b1;
        end else begin
          cnt_d = cnt_q + OFF_W'(1);
        end
      end
      SEQ_HOLD: begin
        if (hold_done) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    busy     = (state_q != SEQ_IDLE);
    scan_off = cnt_q;
  end
endmodule

// File: rtl/pwb_timer.sv
`timescale 1ns/1ps
// Write-cycle timer: done is high in the CYCLES-th cycle after start.
module pwb_timer #(
  parameter int CYCLES = 500000,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    done  = run_q && (cnt_q == '0);
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = CW'(CYCLES - 1);
    end else if (done) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/page_write_buffer.sv
`timescale 1ns/1ps
// Page write staging buffer with commit scan and write-cycle busy interval.
module page_write_buffer #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 128,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              commit,
  input  logic              abort,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic              busy_w, accept, start, scan_en, hold_start, hold_done, clr_mask;
  logic              rd_mask, mask_any_next;
  logic [OFF_W-1:0]  scan_off;
  logic [PAGE_W-1:0] page_w;
  logic [DATA_W-1:0] rd_data;

  always_comb begin
    accept = ~busy_w;
    start  = accept & commit & ~abort & mask_any_next;
  end

  pwb_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .accept(accept), .load_addr(load_addr),
    .addr_in(addr_in), .wr_valid(wr_valid), .wr_byte(wr_byte), .abort(abort),
    .clr_mask(clr_mask), .rd_off(scan_off), .page_o(page_w), .rd_data(rd_data),
    .rd_mask(rd_mask), .mask_any_next(mask_any_next)
  );

  pwb_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .hold_done(hold_done),
    .busy(busy_w), .scan_en(scan_en), .scan_off(scan_off),
    .hold_start(hold_start), .clr_mask(clr_mask)
  );

  pwb_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(hold_start), .done(hold_done)
  );

  always_comb begin
    busy      = busy_w;
    arr_we    = scan_en & rd_mask;
    arr_addr  = {page_w, scan_off};
    arr_wdata = rd_data;
  end
endmodule

// File: rtl/page_write_buffer_chk.sv
`timescale 1ns/1ps
module page_write_buffer_chk #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              commit,
  input logic              abort,
  input logic              load_addr,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              mask_any_next,
  input logic [PAGE_W-1:0] page
);
  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy); // R6
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(commit) && !$past(abort))); // R6
  AST_ABORT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && abort) |=> !busy); // R8
  AST_EMPTY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit && !mask_any_next) |=> !busy); // R7
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W]))); // R2
  AST_OFF_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0]))); // R4
  AST_BUSY_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_addr) |=> $stable(page)); // R9
endmodule

bind page_write_buffer page_write_buffer_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit), .abort(abort),
  .load_addr(load_addr), .arr_we(arr_we), .arr_addr(arr_addr),
  .mask_any_next(mask_any_next), .page(page_w)
);

// File: tb/page_write_buffer_tb.sv
`timescale 1ns/1ps
module page_write_buffer_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PB     = 128;
  localparam int WCYC   = 40;
  localparam int BUSY_LEN = PB + WCYC;

  logic clk, rst_n, load_addr, wr_valid, commit, abort;
  logic [ADDR_W-1:0] addr_in;
  logic [DATA_W-1:0] wr_byte;
  logic busy, arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;

  page_write_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PB),
                      .WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .addr_in(addr_in),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .commit(commit), .abort(abort),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_data [PB];
  bit         m_mask [PB];
  int         m_page = 0;
  int         m_ptr = 0;
  logic [15:0] cap_addr [$];
  logic [7:0]  cap_data [$];

  always @(negedge clk) begin
    if (arr_we === 1'b1) begin
      cap_addr.push_back(arr_addr);
      cap_data.push_back(arr_wdata);
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_load(input int a);
    for (int i = 0; i < PB; i++) m_mask[i] = 1'b0;
    m_page = (a >> 7) & 511;
    m_ptr  = a & 127;
  endfunction

  function automatic void model_put(input logic [7:0] b);
    m_data[m_ptr] = b;
    m_mask[m_ptr] = 1'b1;
    m_ptr = (m_ptr + 1) % PB;
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < PB; i++) m_mask[i] = 1'b0;
  endfunction

  function automatic int model_count();
    int c = 0;
    for (int i = 0; i < PB; i++) if (m_mask[i]) c++;
    return c;
  endfunction

  task automatic ld(input int a);
    load_addr = 1'b1; addr_in = 16'(a);
    @(negedge clk);
    load_addr = 1'b0;
    model_load(a);
  endtask

  task automatic put(input logic [7:0] b);
    wr_valid = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_valid = 1'b0;
    model_put(b);
  endtask

  // Waits out busy, then compares captured writes with the model.
  task automatic wait_verify(input string req, input int exp_len);
    int cnt = 0;
    int err = 0;
    int exp_n;
    while (busy === 1'b1 && cnt < 100000) begin
      cnt++;
      @(negedge clk);
    end
    check_eq(req, "busy cycles", cnt, exp_len);
    exp_n = model_count();
    check_eq(req, "write count", cap_addr.size(), exp_n);
    foreach (cap_addr[k]) begin
      int off = cap_addr[k] & 127;
      if ((cap_addr[k] >> 7) != m_page) err++;
      else if (!m_mask[off]) err++;
      else if (cap_data[k] != m_data[off]) err++;
    end
    check_eq(req, "write mismatches", err, 0);
    model_clear();
    cap_addr.delete();
    cap_data.delete();
  endtask

  task automatic do_commit(input string req);
    int exp_len;
    cap_addr.delete(); cap_data.delete();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    exp_len = (model_count() > 0) ? BUSY_LEN : 0;
    wait_verify(req, exp_len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    int exp_len;
    seed = $urandom(32'h0C0FFEE1);
    rst_n = 1'b0; load_addr = 1'b0; wr_valid = 1'b0; commit = 1'b0; abort = 1'b0;
    addr_in = '0; wr_byte = '0;
    repeat (3) @(negedge clk);
    check_eq("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "busy after reset", int'(busy), 0);
    check_eq("R1", "arr_we after reset", int'(arr_we), 0);

    // R5: single-byte transfer
    ld(16'h1234); put(8'h3C); do_commit("R5");
    // R3: wrap from offset 120 back to 0 of same page
    ld((9'd300 << 7) | 120);
    for (int i = 0; i < 20; i++) put(8'(i + 8'h40));
    do_commit("R3");
    // R4: more than a page, later bytes overwrite
    ld((9'd7 << 7) | 5);
    for (int i = 0; i < PB + 2; i++) put(8'(i * 3 + 1));
    do_commit("R4");
    // R2: top page
    ld(16'hFF80 | 16'd127); put(8'hAA); put(8'h55); do_commit("R2");
    // R7: commit with nothing loaded
    ld(16'h0200); do_commit("R7");
    // R8: abort discards bytes
    ld(16'h0400); put(8'h11); put(8'h22);
    abort = 1'b1; @(negedge clk); abort = 1'b0; model_clear();
    do_commit("R8");
    // R8: abort with commit and byte in the same cycle
    ld(16'h0480); put(8'h33);
    abort = 1'b1; commit = 1'b1; wr_valid = 1'b1; wr_byte = 8'h44;
    @(negedge clk);
    abort = 1'b0; commit = 1'b0; wr_valid = 1'b0; model_clear();
    wait_verify("R8", 0);
    do_commit("R8");
    // R10: byte together with commit is included
    ld(16'h0A10); put(8'h01);
    cap_addr.delete(); cap_data.delete();
    commit = 1'b1; wr_valid = 1'b1; wr_byte = 8'h99;
    @(negedge clk);
    commit = 1'b0; wr_valid = 1'b0; model_put(8'h99);
    wait_verify("R10", BUSY_LEN);
    // R10: byte together with load_addr goes to the new offset
    ld(16'h0B00); put(8'h12);
    load_addr = 1'b1; addr_in = 16'h0C33; wr_valid = 1'b1; wr_byte = 8'h77;
    @(negedge clk);
    load_addr = 1'b0; wr_valid = 1'b0; model_load(16'h0C33); model_put(8'h77);
    do_commit("R10");
    // R11: new address drops uncommitted bytes
    ld(16'h0D00); put(8'hE1); put(8'hE2);
    ld(16'h0E40); put(8'hE3);
    do_commit("R11");
    // R9: requests while busy are ignored
    ld(16'h2050); put(8'hC1); put(8'hC2);
    cap_addr.delete(); cap_data.delete();
    commit = 1'b1; @(negedge clk); commit = 1'b0;
    for (int i = 0; i < 6; i++) begin
      load_addr = 1'b1; addr_in = 16'h7700; wr_valid = 1'b1; wr_byte = 8'hA5;
      abort = i[0]; commit = ~i[0];
      @(negedge clk);
    end
    load_addr = 1'b0; wr_valid = 1'b0; abort = 1'b0; commit = 1'b0;
    wait_verify("R9", BUSY_LEN - 6);
    put(8'hD7);
    check_eq("R9", "pointer after busy", m_ptr, 16'h53 & 127);
    do_commit("R9");
    // R6 / R5 / R3 random transfers
    for (int r = 0; r < 12; r++) begin
      int a = int'($urandom() & 16'hFFFF);
      int n = 1 + int'($urandom() % 200);
      ld(a);
      for (int i = 0; i < n; i++) put(8'($urandom()));
      do_commit("R6");
    end
    exp_len = 0;
    check_eq("R1", "idle at end", int'(busy), exp_len);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule